// File: doc/BRIEF.md
# Latency-Aligned Serial Result Output

This block takes one 12-bit conversion result per pixel and sends it out on a single serial line. Each result comes in as a parallel word with a one-cycle sample strobe. The rising clock edge that samples the strobe is the sampling instant of that pixel. The block holds the word for a fixed latency that depends on the pixel-ratio mode. It then shifts the word out most-significant bit first. Each new bit appears on a falling edge of the clock. The latency is 24.5 clock periods when the pixel period is 12 clocks and 32.5 clock periods when it is 16 clocks.

The latency is longer than one pixel period, so several results can be pending at the same time. A small set of countdown slots holds them. Each slot releases its word when its own count expires. In 16-clock mode the four spare bit slots after each word are driven low. A resynchronisation input drops every pending word and the word currently being shifted. A power-down input turns the output enable off, which stands for a high-impedance data pin. While power-down is high, pending results are dropped and new strobes are ignored. A word-start marker goes high in the period in which each MSB is launched.

Top module: `serial_result_out`

## Requirements
- R1: While reset is asserted, `sdata`, `sdata_oe` and `word_start` are all 0. Once reset is released with `pwr_down` low, `sdata_oe` goes to 1 within four clock cycles.
- R2: With `ratio16` = 0 (12-clock pixels), the MSB of a word is driven on `sdata` from the falling edge 24.5 clock periods after the rising edge that sampled `sample_stb` high with that word.
- R3: The 11 remaining bits follow on the next 11 consecutive falling edges, in order from bit 10 down to bit 0. Each bit changes only on a falling edge.
- R4: With `ratio16` = 1 (16-clock pixels), the MSB appears 32.5 clock periods after the sampling instant. The rest of the word follows as in R3.
- R5: Outside a word's 12 bit slots, `sdata` is 0. This includes the four slots between consecutive words at a 16-clock pixel period.
- R6: `word_start` is 1 for exactly the clock period that begins at the falling edge launching a word's MSB. It is 0 at all other times.
- R7: Strobes arriving every pixel period, 12 clocks apart in one mode and 16 in the other, are all delivered with no word lost or reordered. Up to three words can be pending at once.
- R8: A rising edge that samples `resync` high discards every pending word and the word being shifted. From the next falling edge `sdata` is 0 until a word strobed after the resync is due.
- R9: A rising edge that samples `pwr_down` high takes `sdata_oe` to 0 and `sdata` to 0 at the following falling edge and discards all pending words. Strobes sampled while `pwr_down` is high are ignored. `sdata_oe` returns to 1 at the falling edge after `pwr_down` is sampled low.
- R10: `ratio16` is sampled with each strobe, so every word uses the latency of the mode that was in force at its own sampling instant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; inputs sampled on the rising edge, output bits launched on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ratio16 | input | 1 | 0 selects 12-clock pixels (24.5 latency), 1 selects 16-clock pixels (32.5 latency) |
| sample_stb | input | 1 | High for one rising edge at each sampling instant |
| sample_word | input | 12 | Conversion result tagged to the current strobe |
| resync | input | 1 | Discards all pending and in-flight words |
| pwr_down | input | 1 | Power-down request; disables the output driver |
| sdata | output | 1 | Serial result, MSB first |
| sdata_oe | output | 1 | Output enable; 0 stands for high impedance |
| word_start | output | 1 | High during the period in which an MSB is launched |

## Verification
The bench measures latency from the strobe's own rising edge to the MSB in both modes. It also samples `sdata` once before each falling edge and once after it. A design that launches on the rising edge, or that is off by half a period, then fails even when the bit values are right. Back-to-back words at the minimum pixel period check that pending words are not lost and that the 16-clock padding stays low. A design that pads with stale shift bits, or that keeps too few pending slots, shows wrong bits in those gaps. A resync mid-word, and a power-down window with strobes during it, check that old words are never emitted afterwards and that the enable follows the request with one half-period of delay.

// File: rtl/sdo_pkg.sv
package sdo_pkg;
  typedef enum logic {
    RATIO_12 = 1'b0,
    RATIO_16 = 1'b1
  } ratio_e;
endpackage

// File: rtl/sdo_rst_sync.sv
module sdo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/sdo_pend_queue.sv
module sdo_pend_queue #(
  parameter int WORD_W = 12,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic [CNT_W-1:0]  push_cnt,
  input  logic              flush,
  output logic              due,
  output logic [WORD_W-1:0] due_word
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  vld_q, vld_d, hit;
  logic [CNT_W-1:0]  cnt_q [DEPTH];
  logic [CNT_W-1:0]  cnt_d [DEPTH];
  logic [WORD_W-1:0] wrd_q [DEPTH];
  logic [WORD_W-1:0] wrd_d [DEPTH];
  logic [IDX_W-1:0]  due_idx, free_idx;
  logic              free_any;

  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    assign hit[g] = vld_q[g] && (cnt_q[g] == '0);
  end

  always_comb begin
    due      = 1'b0;
    due_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit[i]) begin
        due     = 1'b1;
        due_idx = IDX_W'(i);
      end
      if (!vld_q[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign due_word = wrd_q[due_idx];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      vld_d[i] = vld_q[i];
      cnt_d[i] = cnt_q[i];
      wrd_d[i] = wrd_q[i];
      if (flush) begin
        vld_d[i] = 1'b0;
      end else begin
        if (vld_q[i]) begin
          if (hit[i]) vld_d[i] = 1'b0;
          else        cnt_d[i] = cnt_q[i] - 1'b1;
        end
        if (push && free_any && (free_idx == IDX_W'(i))) begin
          vld_d[i] = 1'b1;
          cnt_d[i] = push_cnt;
          wrd_d[i] = push_word;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        cnt_q[i] <= '0;
        wrd_q[i] <= '0;
      end
    end else begin
      vld_q <= vld_d;
      for (int i = 0; i < DEPTH; i++) begin
        cnt_q[i] <= cnt_d[i];
        wrd_q[i] <= wrd_d[i];
      end
    end
  end

  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0));

  // R7
  push_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush && free_any) |=> (vld_q != '0));
endmodule

// File: rtl/sdo_shifter.sv
module sdo_shifter #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  output logic              bit_o,
  output logic              start_o
);
  localparam int LEFT_W = $clog2(WORD_W);

  logic [WORD_W-2:0] sh_q, sh_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic              bit_q, bit_d, start_q, start_d;

  always_comb begin
    sh_d    = sh_q;
    left_d  = left_q;
    bit_d   = 1'b0;
    start_d = 1'b0;
    if (clear) begin
      left_d = '0;
    end else if (load) begin
      bit_d   = load_word[WORD_W-1];
      sh_d    = load_word[WORD_W-2:0];
      left_d  = LEFT_W'(WORD_W - 1);
      start_d = 1'b1;
    end else if (left_q != '0) begin
      bit_d  = sh_q[WORD_W-2];
      sh_d   = {sh_q[WORD_W-3:0], 1'b0};
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      left_q  <= '0;
      bit_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      left_q  <= left_d;
      bit_q   <= bit_d;
      start_q <= start_d;
    end
  end

  assign bit_o   = bit_q;
  assign start_o = start_q;

  // R3
  msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> (start_q && (bit_q == $past(load_word[WORD_W-1]))));

  // R5
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((left_q == '0) && !load) |=> !bit_q);
endmodule

// File: rtl/sdo_launch.sv
module sdo_launch (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_i,
  input  logic start_i,
  input  logic en_i,
  output logic sdata,
  output logic sdata_oe,
  output logic word_start
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdata      <= 1'b0;
      sdata_oe   <= 1'b0;
      word_start <= 1'b0;
    end else begin
      sdata      <= bit_i;
      sdata_oe   <= en_i;
      word_start <= start_i;
    end
  end

  // R9
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe |-> (!sdata && !word_start));
endmodule

// File: rtl/serial_result_out.sv
module serial_result_out #(
  parameter int WORD_W = 12,
  parameter int DEPTH  = 4,
  parameter int LAT_12 = 24,
  parameter int LAT_16 = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ratio16,
  input  logic              sample_stb,
  input  logic [WORD_W-1:0] sample_word,
  input  logic              resync,
  input  logic              pwr_down,
  output logic              sdata,
  output logic              sdata_oe,
  output logic              word_start
);
  import sdo_pkg::*;

  localparam int CNT_W = $clog2(LAT_16);
  localparam logic [CNT_W-1:0] LOAD_12 = CNT_W'(LAT_12 - 1);
  localparam logic [CNT_W-1:0] LOAD_16 = CNT_W'(LAT_16 - 1);

  logic              rst_s_n;
  logic              pwr_q;
  logic              flush, push, due, bit_p, start_p;
  logic [WORD_W-1:0] due_word;
  logic [CNT_W-1:0]  push_cnt;
  ratio_e            ratio;

  sdo_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  assign ratio    = ratio_e'(ratio16);
  assign push_cnt = (ratio == RATIO_16) ? LOAD_16 : LOAD_12;
  assign flush    = resync || pwr_down;
  assign push     = sample_stb && !pwr_down;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) pwr_q <= 1'b1;
    else          pwr_q <= pwr_down;
  end

  sdo_pend_queue #(
    .WORD_W (WORD_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
  ) u_queue (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .push      (push),
    .push_word (sample_word),
    .push_cnt  (push_cnt),
    .flush     (flush),
    .due       (due),
    .due_word  (due_word)
  );

  sdo_shifter #(
    .WORD_W (WORD_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .clear     (flush),
    .load      (due),
    .load_word (due_word),
    .bit_o     (bit_p),
    .start_o   (start_p)
  );

  sdo_launch u_launch (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .bit_i      (bit_p),
    .start_i    (start_p),
    .en_i       (!pwr_q),
    .sdata      (sdata),
    .sdata_oe   (sdata_oe),
    .word_start (word_start)
  );

  // R9
  pd_oe_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    pwr_down |=> !sdata_oe);

  // R9
  oe_back_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !pwr_down |=> sdata_oe);
endmodule

// File: tb/tb_serial_result_out.sv
`timescale 1ns/1ps
module tb_serial_result_out;
  logic        clk = 1'b0;
  logic        rst_n, ratio16, sample_stb, resync, pwr_down;
  logic [11:0] sample_word;
  logic        sdata, sdata_oe, word_start;

  always #2.5 clk = ~clk;

  serial_result_out dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ratio16     (ratio16),
    .sample_stb  (sample_stb),
    .sample_word (sample_word),
    .resync      (resync),
    .pwr_down    (pwr_down),
    .sdata       (sdata),
    .sdata_oe    (sdata_oe),
    .word_start  (word_start)
  );

  int    checks = 0, fails = 0, cyc = 0;
  bit    chk_en = 0, prev_ok = 0, done = 0;
  logic  exp_bit [256];
  logic  exp_ws  [256];
  logic  oe_exp = 1'b1, prev_bit = 1'b0;
  string tag = "R1";

  task automatic chk(input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b at cycle %0d", tag, what, got, exp, cyc);
    end
  endtask

  function automatic int lat_of(input logic m);
    return m ? 32 : 24;
  endfunction

  task automatic clear_exp();
    for (int k = 0; k < 256; k++) begin
      exp_bit[k] = 1'b0;
      exp_ws[k]  = 1'b0;
    end
  endtask

  task automatic step(input logic stb, input logic [11:0] w, input logic rsy, input logic pd);
    int idx;
    @(posedge clk);
    cyc++;
    idx = cyc % 256;
    #1;
    if (chk_en && prev_ok) chk("sdata before falling edge", sdata, prev_bit);
    sample_stb  = stb;
    sample_word = w;
    resync      = rsy;
    pwr_down    = pd;
    #3;
    if (chk_en) begin
      chk("sdata", sdata, exp_bit[idx]);
      chk("word_start", word_start, exp_ws[idx]);
      chk("sdata_oe", sdata_oe, oe_exp);
    end
    prev_bit     = exp_bit[idx];
    prev_ok      = chk_en;
    exp_bit[idx] = 1'b0;
    exp_ws[idx]  = 1'b0;
    if (rsy || pd) clear_exp();
    else if (stb) begin
      for (int i = 0; i < 12; i++)
        exp_bit[(cyc + 1 + lat_of(ratio16) + i) % 256] = w[11 - i];
      exp_ws[(cyc + 1 + lat_of(ratio16)) % 256] = 1'b1;
    end
    oe_exp = !pd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 12'h000, 1'b0, 1'b0);
  endtask

  task automatic word_then_gap(input logic [11:0] w, input int gap);
    step(1'b1, w, 1'b0, 1'b0);
    idle(gap - 1);
  endtask

  initial begin
    int unsigned seed, r;
    seed = 32'd20250611;
    r = $urandom(seed);
    clear_exp();
    rst_n = 1'b0; ratio16 = 1'b0; sample_stb = 1'b0; sample_word = '0;
    resync = 1'b0; pwr_down = 1'b0;
    repeat (3) @(posedge clk);
    #4;
    tag = "R1";
    chk("sdata in reset", sdata, 1'b0);
    chk("sdata_oe in reset", sdata_oe, 1'b0);
    chk("word_start in reset", word_start, 1'b0);
    rst_n = 1'b1;
    idle(5);
    chk_en = 1;
    tag = "R1";
    idle(3);

    // R2 R3 R6: single words, 12-clock mode
    tag = "R2 R3 R6";
    word_then_gap(12'h800, 45);
    word_then_gap(12'hFFF, 45);
    word_then_gap(12'h001, 45);
    // R7: back-to-back at 12 clocks
    tag = "R7";
    for (int i = 0; i < 6; i++) word_then_gap(12'hA5C ^ 12'(i * 291), 12);
    idle(45);

    // R4 R5 R10: 16-clock mode with zero padding
    ratio16 = 1'b1;
    tag = "R4 R5 R10";
    word_then_gap(12'hFFF, 50);
    for (int i = 0; i < 6; i++) word_then_gap(12'hFFF ^ 12'(i), 16);
    idle(50);

    // R8: resync in mid-word with words pending
    tag = "R8";
    ratio16 = 1'b0;
    for (int i = 0; i < 3; i++) word_then_gap(12'h7E3 + 12'(i), 12);
    idle(16);
    step(1'b0, 12'h000, 1'b1, 1'b0);
    idle(45);
    word_then_gap(12'h3C3, 45);

    // R9: power-down with strobes during it
    tag = "R9";
    for (int i = 0; i < 2; i++) word_then_gap(12'hB2D, 12);
    for (int i = 0; i < 40; i++) step((i % 12) == 3, 12'hFFF, 1'b0, 1'b1);
    idle(45);
    word_then_gap(12'h9A6, 45);

    // R2 R3 R4 R5 R7 R10: random words and spacing in both modes
    for (int m = 0; m < 2; m++) begin
      ratio16 = m[0];
      tag = m[0] ? "R4 R5 R7 R10" : "R2 R3 R7 R10";
      for (int i = 0; i < 120; i++) begin
        int gap;
        gap = (m[0] ? 16 : 12);
        if (($urandom % 3) == 0) gap = gap + int'($urandom % 20);
        word_then_gap(12'($urandom), gap);
      end
      idle(50);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule